// File: doc/BRIEF.md
# UART Channel Sleep and Wake Controller

This block decides when each channel of a four-channel UART may drop into a low-power sleep state, and when the whole device may stop its crystal oscillator. Software arms channels through one byte of a 32-bit global configuration word. An armed channel sleeps only while it has no interrupt pending. It is pulled back awake at once by a wake event on its own line, or when its arm bit is cleared. Once every channel sleeps at the same time, the block drops the shared oscillator enable.

While the oscillator is stopped, a received byte or serial-line activity on any channel (reported on the per-channel wake-event inputs) restarts it. The block then counts a fixed number of crystal cycles, supplied as a qualifying tick input, before it reports the channels ready again. Any further wake event during that settling window restarts the count. On the return to normal operation a sticky wake interrupt is raised. Its status word carries a "no source pending" code, and a read of that status word clears it.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After synchronous reset the arm bits are 0, no channel sleeps, `osc_en` is 1, every `ch_ready` bit is 1 and `wake_irq` is 0.
- R2: A write to address 0 loads the arm bits for channels 0..3 from `reg_wdata[27:24]`. A read of address 0 returns them in bits 27:24, returns zero in every other bit (bits 31:28 included), and presents the data in the cycle after the read strobe. Writes to address 1 change nothing.
- R3: In normal operation an armed channel with no pending interrupt and no wake event is asleep from the next cycle. A pending interrupt keeps an armed channel awake, and the condition is re-evaluated every cycle.
- R4: Clearing a channel's arm bit wakes that channel on the next evaluation cycle.
- R5: When all four channels are asleep at once, `osc_en` goes low and stays low until a wake condition occurs.
- R6: In normal operation a wake event only keeps its own channel awake for that cycle. `osc_en` stays 1 and the other channels are unaffected.
- R7: While the oscillator is off, a wake event on any channel, or any cleared arm bit, raises `osc_en` on the next cycle. All channels become awake, and all `ch_ready` bits read 0.
- R8: During settling, `ch_ready` stays 0 until 32 `xtal_tick` cycles have been counted. On the edge that takes the 32nd tick, normal operation resumes and `ch_ready` equals the inverse of `ch_asleep`.
- R9: A wake event during settling restarts the tick count from zero.
- R10: `wake_irq` is set when settling completes. A read of address 1 returns bit 7 = wake flag and bits 3:0 = 4'h1 (no source pending) while the flag is set, and returns all zeros otherwise.
- R11: A read of address 1 clears `wake_irq` from the next cycle. Set takes priority if both happen together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One crystal cycle has elapsed (settling counter enable) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = configuration word, 1 = interrupt status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_pend | input | 4 | Per-channel interrupt pending |
| wake_evt | input | 4 | Per-channel receive or line-activity wake event |
| ch_asleep | output | 4 | Per-channel sleep status |
| ch_ready | output | 4 | Per-channel ready (awake and oscillator settled) |
| osc_en | output | 1 | Shared oscillator enable |
| wake_irq | output | 1 | Sticky wake interrupt |

## Verification
Some properties are checked on every cycle. A channel can only start sleeping when it was armed with nothing pending. A disarmed channel never stays asleep. The oscillator is never off unless all channels sleep. No channel is ready while settling runs. Settling only completes on the final counted tick, a wake event always zeroes the count, and the wake flag is only set by a completed settling and cleared by a status read. The exact cycle counts need the bench scenarios: 32 ticks to ready, and a restart from zero after a late wake event. So do the status and configuration read values, the wake caused by clearing an arm bit while the oscillator is off, and the fact that a wake event during normal running leaves the other channels asleep.

// File: rtl/uart_slp_pkg.sv
package uart_slp_pkg;

    localparam int          WORD_W        = 32;
    localparam int          CFG_LSB       = 24;
    localparam int          CFG_FIELD_W   = 8;
    localparam int          STAT_FLAG_BIT = 7;
    localparam logic        ADDR_CFG      = 1'b0;
    localparam logic        ADDR_STAT     = 1'b1;
    localparam logic [3:0]  CODE_NO_SRC   = 4'h1;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_OFF  = 2'd1,
        PWR_WARM = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        CMD_EVAL  = 2'd0,
        CMD_SLEEP = 2'd1,
        CMD_WAKE  = 2'd2
    } chan_cmd_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              addr;
        logic [WORD_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [WORD_W-1:0] stat_word(input logic flag);
        logic [WORD_W-1:0] w;
        w = '0;
        if (flag) begin
            w[STAT_FLAG_BIT] = 1'b1;
            w[3:0]           = CODE_NO_SRC;
        end
        return w;
    endfunction

endpackage

// File: rtl/uart_slp_regs.sv
module uart_slp_regs
    import uart_slp_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic              wake_set,
    output logic [NUM_CH-1:0] sleep_arm,
    output logic              wake_flag,
    output logic [WORD_W-1:0] rdata
);

    logic              cfg_wr;
    logic              stat_rd;
    logic [WORD_W-1:0] cfg_word;

    assign cfg_wr  = req.wr && (req.addr == ADDR_CFG);
    assign stat_rd = req.rd && (req.addr == ADDR_STAT);

    always_comb begin
        cfg_word = '0;
        cfg_word[CFG_LSB +: NUM_CH] = sleep_arm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_arm <= '0;
        end else if (cfg_wr) begin
            sleep_arm <= req.wdata[CFG_LSB +: NUM_CH];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_flag <= 1'b0;
        end else if (wake_set) begin
            wake_flag <= 1'b1;
        end else if (stat_rd) begin
            wake_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            rdata <= (req.addr == ADDR_STAT) ? stat_word(wake_flag) : cfg_word;
        end
    end

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (sleep_arm == $past(req.wdata[CFG_LSB +: NUM_CH])));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.addr == ADDR_CFG) |=> (rdata[WORD_W-1:CFG_LSB+NUM_CH] == '0));

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !wake_set) |=> !wake_flag);

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(wake_set));

endmodule

// File: rtl/uart_slp_chan.sv
module uart_slp_chan
    import uart_slp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cmd_e cmd,
    input  logic      arm,
    input  logic      pend,
    input  logic      evt,
    output logic      want_sleep,
    output logic      asleep
);

    assign want_sleep = arm && !pend && !evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_EVAL:  asleep <= want_sleep;
                CMD_SLEEP: asleep <= 1'b1;
                CMD_WAKE:  asleep <= 1'b0;
                default:   asleep <= 1'b0;
            endcase
        end
    end

    assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(arm && !pend));

    assert_disarm_wakes_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_EVAL && !arm) |=> !asleep);

endmodule

// File: rtl/uart_slp_fsm.sv
module uart_slp_fsm
    import uart_slp_pkg::*;
#(
    parameter int READY_TICKS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       all_want,
    input  logic       any_evt,
    input  logic       any_disarm,
    input  logic       xtal_tick,
    output pwr_state_e state,
    output chan_cmd_e  cmd,
    output logic       wake_done
);

    localparam int CNT_W = (READY_TICKS > 1) ? $clog2(READY_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_TICKS - 1);

    pwr_state_e       state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;

    assign cnt_last  = (cnt == CNT_LAST);
    assign wake_done = (state == PWR_WARM) && !any_evt && xtal_tick && cnt_last;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PWR_RUN:  if (all_want)                state_nxt = PWR_OFF;
            PWR_OFF:  if (any_evt || any_disarm)   state_nxt = PWR_WARM;
            PWR_WARM: if (wake_done)               state_nxt = PWR_RUN;
            default:                               state_nxt = PWR_RUN;
        endcase
    end

    always_comb begin
        cmd = CMD_EVAL;
        if (state_nxt == PWR_OFF) begin
            cmd = CMD_SLEEP;
        end else if (state_nxt == PWR_WARM || state == PWR_WARM) begin
            cmd = CMD_WAKE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (state != PWR_WARM || any_evt) begin
            cnt <= '0;
        end else if (xtal_tick) begin
            cnt <= cnt_last ? '0 : cnt + 1'b1;
        end
    end

    assert_settle_done_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_RUN && $past(state) == PWR_WARM) |-> $past(cnt_last && xtal_tick));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_WARM && any_evt) |=> (state == PWR_WARM && cnt == '0));

    assert_off_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_OFF && !any_evt && !any_disarm) |=> (state == PWR_OFF));

endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uart_slp_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int READY_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xtal_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] irq_pend,
    input  logic [NUM_CH-1:0] wake_evt,
    output logic [NUM_CH-1:0] ch_asleep,
    output logic [NUM_CH-1:0] ch_ready,
    output logic              osc_en,
    output logic              wake_irq
);

    reg_req_t          req;
    logic [NUM_CH-1:0] sleep_arm;
    logic [NUM_CH-1:0] want;
    logic              wake_done;
    pwr_state_e        state;
    chan_cmd_e         cmd;

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};

    uart_slp_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wake_set  (wake_done),
        .sleep_arm (sleep_arm),
        .wake_flag (wake_irq),
        .rdata     (reg_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        uart_slp_chan chan_i (
            .clk        (clk),
            .rst        (rst),
            .cmd        (cmd),
            .arm        (sleep_arm[g]),
            .pend       (irq_pend[g]),
            .evt        (wake_evt[g]),
            .want_sleep (want[g]),
            .asleep     (ch_asleep[g])
        );
    end

    uart_slp_fsm #(.READY_TICKS(READY_TICKS)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .all_want   (&want),
        .any_evt    (|wake_evt),
        .any_disarm (!(&sleep_arm)),
        .xtal_tick  (xtal_tick),
        .state      (state),
        .cmd        (cmd),
        .wake_done  (wake_done)
    );

    assign osc_en   = (state != PWR_OFF);
    assign ch_ready = (state == PWR_RUN) ? ~ch_asleep : '0;

    assert_osc_off_all_R5: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (&ch_asleep));

    assert_ready_needs_osc_R8: assert property (@(posedge clk) disable iff (rst)
        (|ch_ready) |-> osc_en);

    assert_run_evt_keeps_osc_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_RUN && (|wake_evt)) |=> osc_en);

endmodule

// File: tb/uart_sleep_ctrl_tb_top.sv
module uart_sleep_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        string       req;
        logic [31:0] exp;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xtal_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_pend = '0;
    logic [3:0]  wake_evt = '0;
    logic [3:0]  ch_asleep;
    logic [3:0]  ch_ready;
    logic        osc_en;
    logic        wake_irq;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic        rd_seen = 1'b0;
    exp_item_t   rd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_sleep_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .xtal_tick (xtal_tick),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_pend  (irq_pend),
        .wake_evt  (wake_evt),
        .ch_asleep (ch_asleep),
        .ch_ready  (ch_ready),
        .osc_en    (osc_en),
        .wake_irq  (wake_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic addr, input logic [31:0] data);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        step(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // driver: pushes the expected read value, the monitor compares it
    task automatic rd_reg(input logic addr, input string req, input logic [31:0] exp);
        exp_item_t it;
        it.req = req; it.exp = exp;
        rd_q.push_back(it);
        reg_rd = 1'b1; reg_addr = addr;
        step(1);
        reg_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_q.size() == 0) begin
                chk("read scoreboard underflow", 32'h1, 32'h0);
            end else begin
                exp_item_t it;
                it = rd_q.pop_front();
                chk(it.req, reg_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1: reset state
        chk("R1 asleep", {28'h0, ch_asleep}, 32'h0);
        chk("R1 osc_en", {31'h0, osc_en}, 32'h1);
        chk("R1 ready", {28'h0, ch_ready}, 32'hF);
        chk("R1 wake_irq", {31'h0, wake_irq}, 32'h0);
        rd_reg(1'b0, "R1 cfg reset", 32'h0);

        // R2 and R3: arm all with every channel pending
        irq_pend = 4'hF;
        wr_reg(1'b0, 32'hFF00_0000);
        rd_reg(1'b0, "R2 cfg readback", 32'h0F00_0000);
        chk("R3 pending keeps awake", {28'h0, ch_asleep}, 32'h0);

        irq_pend = 4'b0001;
        step(1);
        chk("R3 sleep idle channels", {28'h0, ch_asleep}, 32'hE);
        chk("R3 ready of pending ch", {28'h0, ch_ready}, 32'h1);

        // R4: disarm channel 3
        wr_reg(1'b0, 32'h0600_0000);
        step(1);
        chk("R4 disarmed ch3 awake", {28'h0, ch_asleep}, 32'h6);

        // R6: wake event in normal running
        wake_evt = 4'b0100;
        step(1);
        wake_evt = 4'b0000;
        chk("R6 only ch2 woken", {28'h0, ch_asleep}, 32'h2);
        chk("R6 osc stays", {31'h0, osc_en}, 32'h1);
        step(1);
        chk("R6 ch2 resleeps", {28'h0, ch_asleep}, 32'h6);

        // R5: all asleep gates oscillator
        irq_pend = 4'b0000;
        wr_reg(1'b0, 32'h0F00_0000);
        step(1);
        chk("R5 all asleep", {28'h0, ch_asleep}, 32'hF);
        chk("R5 osc off", {31'h0, osc_en}, 32'h0);
        xtal_tick = 1'b1;
        step(3);
        xtal_tick = 1'b0;
        chk("R5 osc stays off", {31'h0, osc_en}, 32'h0);

        // R7: wake from off
        wake_evt = 4'b1000;
        step(1);
        wake_evt = 4'b0000;
        chk("R7 osc on", {31'h0, osc_en}, 32'h1);
        chk("R7 none asleep", {28'h0, ch_asleep}, 32'h0);
        chk("R7 none ready", {28'h0, ch_ready}, 32'h0);

        // R9: restart after partial settle
        xtal_tick = 1'b1;
        step(20);
        xtal_tick = 1'b0;
        chk("R8 not ready mid settle", {28'h0, ch_ready}, 32'h0);
        wake_evt = 4'b0001;
        step(1);
        wake_evt = 4'b0000;
        irq_pend = 4'b0001;
        xtal_tick = 1'b1;
        step(31);
        chk("R9 count restarted", {28'h0, ch_ready}, 32'h0);
        chk("R10 no irq yet", {31'h0, wake_irq}, 32'h0);
        step(1);
        xtal_tick = 1'b0;
        chk("R8 ready after 32 ticks", {28'h0, ch_ready}, 32'hF);
        chk("R10 wake irq set", {31'h0, wake_irq}, 32'h1);
        step(1);
        chk("R3 resleep after wake", {28'h0, ch_asleep}, 32'hE);

        // R10, R11: status read and clear
        rd_reg(1'b1, "R10 status word", 32'h0000_0081);
        chk("R11 irq cleared", {31'h0, wake_irq}, 32'h0);
        rd_reg(1'b1, "R10 status idle", 32'h0);

        // R7: disarm while off
        irq_pend = 4'b0000;
        step(1);
        chk("R5 off again", {31'h0, osc_en}, 32'h0);
        wr_reg(1'b0, 32'h0700_0000);
        step(1);
        chk("R7 disarm wakes osc", {31'h0, osc_en}, 32'h1);
        chk("R7 disarm not ready", {28'h0, ch_ready}, 32'h0);

        // R2: reserved bits and status-address writes
        wr_reg(1'b0, 32'hF000_0000);
        rd_reg(1'b0, "R2 reserved ignored", 32'h0);
        wr_reg(1'b1, 32'h0F00_0000);
        rd_reg(1'b0, "R2 stat write ignored", 32'h0);

        xtal_tick = 1'b1;
        step(32);
        xtal_tick = 1'b0;
        chk("R8 ready disarmed", {28'h0, ch_ready}, 32'hF);
        chk("R10 irq after second wake", {31'h0, wake_irq}, 32'h1);
        step(2);
        report();
    end

endmodule